// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, A and B. Each bus has its own holding register, and each register is loaded from its own bus on the rising edge of its own clock. Whichever bus is driven gets either the live value of the opposite bus, passed straight through with no register in the path, or the contents of the opposite bus's register.

A single active-low enable and a direction select decide which bus, if any, is driven. Register loading does not depend on either of them, so a register can take a snapshot of its bus while both buses are isolated. Each bus pin is modelled as a separate input, output and output-enable, so no tristate net exists inside the block.

A synchronous active-high reset clears each register at that register's own clock edge. The two clocks are treated as unrelated domains.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_a2b` with `rst` low, the A register takes the value on `a_in`.
- R2: On each rising edge of `clk_b2a` with `rst` low, the B register takes the value on `b_in`.
- R3: Register loading happens whatever the values of `oe_n` and `dir_to_b`, including while both buses are isolated.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R5: While `oe_n` is 0 and `dir_to_b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: While `oe_n` is 0 and `dir_to_b` is 0, `a_oe` is 1 and `b_oe` is 0.
- R7: While `b_oe` is 1, `b_out` equals `a_in` combinationally when `sel_a2b` is 0, and equals the A register when `sel_a2b` is 1.
- R8: While `a_oe` is 1, `a_out` equals `b_in` combinationally when `sel_b2a` is 0, and equals the B register when `sel_b2a` is 1.
- R9: In stored mode, a rising edge on the matching clock both loads the register and changes the driven output to the new value after that edge.
- R10: A rising clock edge with `rst` at 1 clears that clock's register to 0. `rst` has no effect on `a_oe` or `b_oe`.
- R11: Whenever a bus's output-enable is 0, its output value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, applied at each register's own clock edge |
| clk_a2b | input | 1 | Load clock of the A register |
| clk_b2a | input | 1 | Load clock of the B register |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir_to_b | input | 1 | 1: drive the B bus; 0: drive the A bus |
| sel_a2b | input | 1 | Source for B: 0 = live A, 1 = A register |
| sel_b2a | input | 1 | Source for A: 0 = live B, 1 = B register |
| a_in | input | 8 | A bus input value |
| a_out | output | 8 | A bus output value |
| a_oe | output | 1 | A bus output-enable |
| b_in | input | 8 | B bus input value |
| b_out | output | 8 | B bus output value |
| b_oe | output | 1 | B bus output-enable |

## Verification
The directed patterns are the following:
- A register loaded while both buses are isolated and then read out in stored mode. This separates always-on capture from enable-gated capture.
- A stored-mode output checked just before and just after a clock edge. This shows whether the output follows the register or the live bus.
- A reset with each enable setting. This shows whether reset leaks into the output-enables.

Random input patterns then cover every combination of enable, direction and source select. Each result is compared with a model that records both registers on their own clocks, so a swapped select, a swapped direction or a wrong clock domain produces a mismatch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Output-enable for one side: want_b selects the B-side decode
  function automatic logic side_enable(input logic oe_n, input logic dir_to_b,
                                       input logic want_b);
    return !oe_n && (dir_to_b == want_b);
  endfunction

  // Source selection followed by enable gating
  function automatic logic [7:0] side_value(input logic en, input logic use_reg,
                                            input logic [7:0] live,
                                            input logic [7:0] held);
    return en ? (use_reg ? held : live) : 8'h00;
  endfunction
endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1 R2 R3
  cap_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(d)));
endmodule

// File: rtl/xcvr_side_drv.sv
module xcvr_side_drv #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         use_reg,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] value
);
  always_comb begin
    if (!en)         value = '0;
    else if (use_reg) value = held;
    else             value = live;
  end

  always_comb begin
    // R11
    quiet_chk: assert (en || value == '0);
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         rst,
  input  logic         clk_a2b,
  input  logic         clk_b2a,
  input  logic         oe_n,
  input  logic         dir_to_b,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;

  logic [W-1:0] a_held;
  logic [W-1:0] b_held;
  logic         drive_a;
  logic         drive_b;

  assign drive_a = side_enable(oe_n, dir_to_b, 1'b0);
  assign drive_b = side_enable(oe_n, dir_to_b, 1'b1);
  assign a_oe    = drive_a;
  assign b_oe    = drive_b;

  xcvr_hold_reg #(.W(W)) u_areg (.clk(clk_a2b), .rst(rst), .d(a_in), .q(a_held));
  xcvr_hold_reg #(.W(W)) u_breg (.clk(clk_b2a), .rst(rst), .d(b_in), .q(b_held));

  xcvr_side_drv #(.W(W)) u_to_b (.en(drive_b), .use_reg(sel_a2b), .live(a_in),
                                 .held(a_held), .value(b_out));
  xcvr_side_drv #(.W(W)) u_to_a (.en(drive_a), .use_reg(sel_b2a), .live(b_in),
                                 .held(b_held), .value(a_out));

  always_comb begin
    // R4
    iso_chk: assert (!oe_n || (!a_oe && !b_oe));
    // R5 R6
    excl_chk: assert (oe_n || (a_oe ^ b_oe));
  end

  // R9
  stored_b_chk: assert property (@(posedge clk_a2b) disable iff (rst)
    (!rst && b_oe && sel_a2b) |=> (!b_oe || !sel_a2b || b_out == $past(a_in)));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  logic rst, clk_a, clk_b, oe_n, dir_to_b, sel_a2b, sel_b2a;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;
  logic [7:0] mdl_a, mdl_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bus_xcvr_reg u0 (.rst(rst), .clk_a2b(clk_a), .clk_b2a(clk_b), .oe_n(oe_n),
    .dir_to_b(dir_to_b), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  initial begin clk_a = 0; forever #2.5 clk_a = ~clk_a; end
  initial begin clk_b = 0; #1; forever #5 clk_b = ~clk_b; end

  // reference registers, one per clock domain
  always @(posedge clk_a) mdl_a <= rst ? 8'h00 : a_in;
  always @(posedge clk_b) mdl_b <= rst ? 8'h00 : b_in;

  function automatic logic exp_oe_b(logic g_n, logic d);
    return (g_n == 1'b0) && (d == 1'b1);
  endfunction
  function automatic logic exp_oe_a(logic g_n, logic d);
    return (g_n == 1'b0) && (d == 1'b0);
  endfunction
  function automatic logic [7:0] exp_val(logic on, logic s, logic [7:0] live, logic [7:0] st);
    if (on == 1'b0) return 8'h00;
    return (s == 1'b1) ? st : live;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R4/R5/R6 a_oe"}, {7'd0, a_oe}, {7'd0, exp_oe_a(oe_n, dir_to_b)});
    chk({tag, " R4/R5/R6 b_oe"}, {7'd0, b_oe}, {7'd0, exp_oe_b(oe_n, dir_to_b)});
    chk({tag, " R7/R11 b_out"}, b_out, exp_val(exp_oe_b(oe_n, dir_to_b), sel_a2b, a_in, mdl_a));
    chk({tag, " R8/R11 a_out"}, a_out, exp_val(exp_oe_a(oe_n, dir_to_b), sel_b2a, b_in, mdl_b));
  endtask

  task automatic step; @(negedge clk_a); endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; oe_n = 0; dir_to_b = 1; sel_a2b = 1; sel_b2a = 1;
    a_in = 8'hFF; b_in = 8'hEE;
    repeat (5) step;
    #1;
    // R10: reset clears both registers, enables unaffected
    chk("R10 b_out stored after reset", b_out, 8'h00);
    chk("R10 b_oe during reset", {7'd0, b_oe}, 8'h01);
    dir_to_b = 0; #0.5;
    chk("R10 a_out stored after reset", a_out, 8'h00);
    chk("R10 a_oe during reset", {7'd0, a_oe}, 8'h01);
    step; rst = 0;
    // R3 R1: load A while isolated
    oe_n = 1; a_in = 8'h5A; b_in = 8'hA5;
    repeat (4) step;
    #1;
    chk("R4 isolated a_oe", {7'd0, a_oe}, 8'h00);
    chk("R4 isolated b_oe", {7'd0, b_oe}, 8'h00);
    chk("R11 isolated b_out", b_out, 8'h00);
    step;
    oe_n = 0; dir_to_b = 1; sel_a2b = 1; a_in = 8'h00; #1;
    chk("R3 R1 A reg loaded while isolated", b_out, 8'h5A);
    sel_a2b = 0; #1;
    chk("R7 transparent b_out", b_out, 8'h00);
    // R2 R3: B side
    dir_to_b = 0; sel_b2a = 1; b_in = 8'h11; #1;
    chk("R3 R2 B reg loaded while isolated", a_out, 8'hA5);
    sel_b2a = 0; #1;
    chk("R8 transparent a_out", a_out, 8'h11);
    // R9: stored mode edge updates output
    step;
    dir_to_b = 1; sel_a2b = 1; a_in = 8'hC3; #1;
    chk("R9 before edge", b_out, 8'h00);
    @(posedge clk_a); #1;
    chk("R9 after edge", b_out, 8'hC3);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step;
      rst      = ($urandom_range(0, 40) == 0);
      oe_n     = $urandom_range(0, 3) == 0;
      dir_to_b = $urandom_range(0, 1);
      sel_a2b  = $urandom_range(0, 1);
      sel_b2a  = $urandom_range(0, 1);
      a_in     = 8'($urandom);
      b_in     = 8'($urandom);
      #1;
      check_all("rand");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule